// File: doc/BRIEF.md
# Sequential Signed Restoring Divider

This block divides one N-bit two's complement number by another over several clock cycles. A one-cycle `start` pulse captures the operands. The dividend is placed, sign-extended to 2N bits, across a partial-remainder register and a quotient register. The divisor is held in its own register. `busy` stays high while the work runs. `done` then pulses once, and at that point the signed quotient and remainder are valid on the outputs.

Each iteration shifts the remainder/quotient pair left by one bit. It then tries an add or a subtract: subtract when the partial remainder and the divisor have the same sign, add when they do not. The trial is kept, and a 1 enters the quotient, when the partial remainder keeps its sign. It is also kept when the result is exactly zero and no unconsumed dividend bits are left. In every other case the partial remainder is put back and a 0 enters the quotient. After N iterations a final step negates the quotient when the operand signs differ. The partial remainder becomes the remainder. A zero divisor is reported with a flag at completion; the block does not stop on it.

Top module: `sdiv_restore`

## Requirements
- R1: After a synchronous reset, `busy`, `done` and `div_by_zero` are low, and `quotient` and `remainder` are zero.
- R2: A `start` sampled high while `busy` is low begins a division, and `busy` is high from the next cycle. `done` is high for exactly one cycle. It rises after the (N+2)th rising edge, counting the edge that sampled `start`. `busy` is low in that cycle.
- R3: `start` is ignored while `busy` is high. The running division is neither restarted nor given new operands, and its completion time is unchanged.
- R4: For every divisor other than zero, the quotient rounds toward zero and dividend = quotient × divisor + remainder. This holds for all four sign combinations. The single overflowing pair, most-negative ÷ −1, is excluded and is covered by R9.
- R5: The remainder is zero or has the sign of the dividend, and its magnitude is below that of the divisor.
- R6: A negative dividend that divides exactly yields a zero remainder and the exact quotient (for example −6 ÷ 2 gives −3 rem 0).
- R7: `div_by_zero` is high in the `done` cycle exactly when the captured divisor was zero, and it is low in every other cycle.
- R8: `quotient` and `remainder` change only at the edge that raises `done`. They hold their values while `busy` is high and while idle, whatever the operand inputs do.
- R9: Most-negative ÷ −1 wraps: the quotient is the most negative value (0x80 for N=8) and the remainder is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a division with the present operands |
| dividend | input | N | Two's complement dividend |
| divisor | input | N | Two's complement divisor |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | N | Signed quotient, truncated toward zero |
| remainder | output | N | Signed remainder, sign of the dividend |
| div_by_zero | output | 1 | Divisor was zero; valid with `done` |

## Verification
The bench builds the block with the default N = 8. At that width the extreme operands −128, 127, −1 and 1 can be written directly in a vector table, and the wrapping pair −128 ÷ −1 is within reach. Each division takes only ten cycles, so a long run of random operands covering all sign pairings fits easily beside the directed cases. Those directed cases are exact negative-dividend division, a divisor as large as the dividend, a zero divisor, and a `start` raised while the block is busy.

// File: rtl/sdiv_pkg.sv
`timescale 1ns/1ps
package sdiv_pkg;

    // Sequencer states of the divider.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ITER = 2'd1,
        ST_FIX  = 2'd2
    } div_state_e;

    // Operand attributes captured at load and used at the fix-up step.
    typedef struct packed {
        logic dvd_neg;
        logic dsr_neg;
        logic dsr_zero;
    } div_flags_t;

    // Quotient magnitude must be negated when the operand signs differ.
    function automatic logic flags_negate(input div_flags_t f);
        return f.dvd_neg ^ f.dsr_neg;
    endfunction

endpackage

// File: rtl/sdiv_ctrl.sv
`timescale 1ns/1ps
module sdiv_ctrl
    import sdiv_pkg::*;
#(
    parameter int N = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic load,
    output logic step_en,
    output logic fix_en,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(N + 1);
    localparam logic [CW-1:0] LAST_ITER = CW'(N - 1);

    div_state_e     state_q;
    div_state_e     state_d;
    logic [CW-1:0]  iter_q;
    logic           done_q;

    assign load    = (state_q == ST_IDLE) && start;
    assign step_en = (state_q == ST_ITER);
    assign fix_en  = (state_q == ST_FIX);
    assign busy    = (state_q != ST_IDLE);
    assign done    = done_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)               state_d = ST_ITER;
            ST_ITER: if (iter_q == LAST_ITER) state_d = ST_FIX;
            ST_FIX:                           state_d = ST_IDLE;
            default:                          state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            iter_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= fix_en;
            if (load) begin
                iter_q <= '0;
            end else if (step_en) begin
                iter_q <= iter_q + CW'(1);
            end
        end
    end

endmodule

// File: rtl/sdiv_step.sv
`timescale 1ns/1ps
module sdiv_step #(
    parameter int N = 8
) (
    input  logic [N-1:0] a_cur,
    input  logic [N-1:0] q_cur,
    input  logic [N-1:0] m_cur,
    input  logic [N-1:0] mask_cur,
    output logic [N-1:0] a_next,
    output logic [N-1:0] q_next,
    output logic [N-1:0] mask_next
);
    // One extra bit keeps the shifted partial remainder exact.
    logic [N:0] a_sh;
    logic [N:0] m_ext;
    logic [N:0] trial;
    logic [N-1:0] q_sh;
    logic       rest_nz;
    logic       keep;

    always_comb begin
        a_sh      = {a_cur, q_cur[N-1]};
        q_sh      = {q_cur[N-2:0], 1'b0};
        m_ext     = {m_cur[N-1], m_cur};
        mask_next = mask_cur << 1;
        // Unconsumed dividend bits still waiting in the quotient register.
        rest_nz   = |(q_sh & mask_next);

        if (a_sh[N] == m_ext[N]) begin
            trial = a_sh - m_ext;
        end else begin
            trial = a_sh + m_ext;
        end

        keep = (trial[N] == a_sh[N]) || ((trial == '0) && !rest_nz);

        a_next = keep ? trial[N-1:0] : a_sh[N-1:0];
        q_next = {q_sh[N-1:1], keep};
    end

endmodule

// File: rtl/sdiv_fixup.sv
`timescale 1ns/1ps
module sdiv_fixup #(
    parameter int N = 8
) (
    input  logic [N-1:0] q_mag,
    input  logic         negate,
    output logic [N-1:0] quot
);
    always_comb begin
        quot = negate ? -q_mag : q_mag;
    end
endmodule

// File: rtl/sdiv_restore.sv
`timescale 1ns/1ps
module sdiv_restore
    import sdiv_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [N-1:0] dividend,
    input  logic [N-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [N-1:0] quotient,
    output logic [N-1:0] remainder,
    output logic         div_by_zero
);
    logic         load;
    logic         step_en;
    logic         fix_en;

    logic [N-1:0] a_q;
    logic [N-1:0] q_q;
    logic [N-1:0] m_q;
    logic [N-1:0] mask_q;
    div_flags_t   flags_q;

    logic [N-1:0] a_nx;
    logic [N-1:0] q_nx;
    logic [N-1:0] mask_nx;
    logic [N-1:0] fix_quot;

    logic [N-1:0] quot_q;
    logic [N-1:0] rem_q;
    logic         dz_q;

    sdiv_ctrl #(.N(N)) ctrl_i (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .load    (load),
        .step_en (step_en),
        .fix_en  (fix_en),
        .busy    (busy),
        .done    (done)
    );

    sdiv_step #(.N(N)) step_i (
        .a_cur     (a_q),
        .q_cur     (q_q),
        .m_cur     (m_q),
        .mask_cur  (mask_q),
        .a_next    (a_nx),
        .q_next    (q_nx),
        .mask_next (mask_nx)
    );

    sdiv_fixup #(.N(N)) fix_i (
        .q_mag  (q_q),
        .negate (flags_negate(flags_q)),
        .quot   (fix_quot)
    );

    // Working registers: load, then one shift-and-trial per cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            a_q     <= '0;
            q_q     <= '0;
            m_q     <= '0;
            mask_q  <= '0;
            flags_q <= '0;
        end else if (load) begin
            a_q              <= {N{dividend[N-1]}};
            q_q              <= dividend;
            m_q              <= divisor;
            mask_q           <= '1;
            flags_q.dvd_neg  <= dividend[N-1];
            flags_q.dsr_neg  <= divisor[N-1];
            flags_q.dsr_zero <= (divisor == '0);
        end else if (step_en) begin
            a_q    <= a_nx;
            q_q    <= q_nx;
            mask_q <= mask_nx;
        end
    end

    // Result registers: written only by the fix-up step.
    always_ff @(posedge clk) begin
        if (rst) begin
            quot_q <= '0;
            rem_q  <= '0;
            dz_q   <= 1'b0;
        end else begin
            dz_q <= fix_en & flags_q.dsr_zero;
            if (fix_en) begin
                quot_q <= fix_quot;
                rem_q  <= a_q;
            end
        end
    end

    assign quotient    = quot_q;
    assign remainder   = rem_q;
    assign div_by_zero = dz_q;

endmodule

// File: rtl/sdiv_restore_chk.sv
`timescale 1ns/1ps
module sdiv_restore_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic [N-1:0] dividend,
    input logic [N-1:0] divisor,
    input logic         busy,
    input logic         done,
    input logic [N-1:0] quotient,
    input logic [N-1:0] remainder,
    input logic         div_by_zero
);
    int unsigned    run_cnt;
    logic [N-1:0]   dvd_l;
    logic [N-1:0]   dsr_l;
    logic           ovf_pair;
    logic signed [2*N:0] recon;
    logic signed [2*N:0] dvd_ext;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= 0;
            dvd_l   <= '0;
            dsr_l   <= '0;
        end else begin
            run_cnt <= busy ? run_cnt + 1 : 0;
            if (start && !busy) begin
                dvd_l <= dividend;
                dsr_l <= divisor;
            end
        end
    end

    always_comb begin
        ovf_pair = (dvd_l == {1'b1, {(N-1){1'b0}}}) && (dsr_l == '1);
        recon    = $signed({{(N+1){quotient[N-1]}}, quotient})
                 * $signed({{(N+1){dsr_l[N-1]}}, dsr_l})
                 + $signed({{(N+1){remainder[N-1]}}, remainder});
        dvd_ext  = $signed({{(N+1){dvd_l[N-1]}}, dvd_l});
    end

    // R2: completion pulse lands N+1 cycles after busy rises
    p_done_timing_r2: assert property (@(posedge clk) disable iff (rst)
        done |-> (run_cnt == N + 1));

    // R2: done is a single-cycle pulse and never overlaps busy
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_done_not_busy_r2: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R3: a start during busy never stretches the run
    p_restart_ignored_r3: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_cnt <= N));

    // R4: reconstruction identity at completion
    p_identity_r4: assert property (@(posedge clk) disable iff (rst)
        (done && !div_by_zero && !ovf_pair) |-> (recon == dvd_ext));

    // R5: remainder sign follows the dividend
    p_rem_sign_r5: assert property (@(posedge clk) disable iff (rst)
        (done && !div_by_zero && (remainder != '0)) |-> (remainder[N-1] == dvd_l[N-1]));

    // R7: zero-divisor flag matches the captured divisor, only with done
    p_dz_flag_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> (div_by_zero == (dsr_l == '0)));
    p_dz_only_done_r7: assert property (@(posedge clk) disable iff (rst)
        div_by_zero |-> done);

    // R8: results hold throughout a running division
    p_hold_busy_r8: assert property (@(posedge clk) disable iff (rst)
        busy |-> ($stable(quotient) && $stable(remainder)));

endmodule

bind sdiv_restore sdiv_restore_chk #(.N(N)) chk_i (.*);

// File: tb/sdiv_restore_tb_top.sv
`timescale 1ns/1ps
module sdiv_restore_tb_top;
    localparam int N     = 8;
    localparam int NVEC  = 16;
    localparam int NRAND = 300;

    // {dividend, divisor, quotient, remainder}, one byte each
    localparam logic [31:0] VEC [NVEC] = '{
        32'h6407_0E02,   //  100 /  7
        32'h9C07_F2FE,   // -100 /  7
        32'h64F9_F202,   //  100 / -7
        32'h9CF9_0EFE,   // -100 / -7
        32'hF902_FDFF,   //   -7 /  2
        32'hFA02_FD00,   //   -6 /  2
        32'h8080_0100,   // -128 / -128
        32'h7F01_7F00,   //  127 /  1
        32'h0509_0005,   //    5 /  9
        32'hFB09_00FB,   //   -5 /  9
        32'h8001_8000,   // -128 /  1
        32'h00FD_0000,   //    0 / -3
        32'hC004_F000,   //  -64 /  4
        32'h7F80_007F,   //  127 / -128
        32'h8180_0081,   // -127 / -128
        32'h0D03_0401    //   13 /  3
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [N-1:0] dividend = '0;
    logic [N-1:0] divisor = '0;
    logic         busy;
    logic         done;
    logic [N-1:0] quotient;
    logic [N-1:0] remainder;
    logic         div_by_zero;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sdiv_restore #(.N(N)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .dividend    (dividend),
        .divisor     (divisor),
        .busy        (busy),
        .done        (done),
        .quotient    (quotient),
        .remainder   (remainder),
        .div_by_zero (div_by_zero)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Issues one division; returns the cycle count at which done was seen
    // (1 = the negedge just after the edge that sampled start).
    task automatic run_div(input logic [N-1:0] a, input logic [N-1:0] b, output int cyc);
        @(negedge clk);
        dividend = a;
        divisor  = b;
        start    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cyc   = 1;
        while (!done && cyc < 60) begin
            @(posedge clk);
            @(negedge clk);
            cyc++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R2 watchdog actual=expired expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int cyc;
        logic [N-1:0] hq;
        logic [N-1:0] hr;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 div_by_zero", 32'(div_by_zero), 32'd0);
        chk("R1 quotient", 32'(quotient), 32'd0);
        chk("R1 remainder", 32'(remainder), 32'd0);
        rst = 1'b0;

        // Vector table: R4 quotient, R5 remainder, R2 latency
        for (int i = 0; i < NVEC; i++) begin
            run_div(VEC[i][31:24], VEC[i][23:16], cyc);
            chk("R2 latency", 32'(cyc), 32'(N + 2));
            chk("R4 quotient", 32'(quotient), 32'(VEC[i][15:8]));
            chk("R5 remainder", 32'(remainder), 32'(VEC[i][7:0]));
            chk("R7 flag low", 32'(div_by_zero), 32'd0);
        end

        // R2: busy behaviour around a run
        @(negedge clk);
        dividend = 8'd50; divisor = 8'd6; start = 1'b1;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        chk("R2 busy after start", 32'(busy), 32'd1);
        while (!done) begin @(posedge clk); @(negedge clk); end
        chk("R2 busy low at done", 32'(busy), 32'd0);
        @(posedge clk); @(negedge clk);
        chk("R2 done one cycle", 32'(done), 32'd0);

        // R3: start during busy is ignored
        @(negedge clk);
        dividend = 8'd100; divisor = 8'd7; start = 1'b1;
        @(posedge clk); @(negedge clk);
        cyc = 1;
        dividend = 8'h81; divisor = 8'd3;   // start still high, new operands
        @(posedge clk); @(negedge clk);
        cyc++;
        @(posedge clk); @(negedge clk);
        cyc++;
        start = 1'b0;
        while (!done && cyc < 60) begin @(posedge clk); @(negedge clk); cyc++; end
        chk("R3 latency", 32'(cyc), 32'(N + 2));
        chk("R3 quotient", 32'(quotient), 32'h0E);
        chk("R3 remainder", 32'(remainder), 32'h02);

        // R6: exact negative-dividend divisions
        run_div(8'hFA, 8'h02, cyc);
        chk("R6 quotient -6/2", 32'(quotient), 32'hFD);
        chk("R6 remainder -6/2", 32'(remainder), 32'h00);
        run_div(8'hA0, 8'hF0, cyc);   // -96 / -16
        chk("R6 quotient -96/-16", 32'(quotient), 32'h06);
        chk("R6 remainder -96/-16", 32'(remainder), 32'h00);
        run_div(8'h91, 8'h07, cyc);   // -111 / 7 = -15 rem -6
        chk("R6 quotient -111/7", 32'(quotient), 32'hF1);
        chk("R6 remainder -111/7", 32'(remainder), 32'hFA);

        // R9: overflow pair wraps
        run_div(8'h80, 8'hFF, cyc);
        chk("R9 quotient", 32'(quotient), 32'h80);
        chk("R9 remainder", 32'(remainder), 32'h00);

        // R7: zero divisor flagged with done only
        run_div(8'd37, 8'd0, cyc);
        chk("R7 latency", 32'(cyc), 32'(N + 2));
        chk("R7 flag with done", 32'(div_by_zero), 32'd1);
        @(posedge clk); @(negedge clk);
        chk("R7 flag clears", 32'(div_by_zero), 32'd0);

        // R8: results hold while idle with changing inputs
        run_div(8'hE7, 8'h05, cyc);   // -25 / 5 = -5 rem 0
        hq = quotient;
        hr = remainder;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            dividend = 8'(k * 37 + 3);
            divisor  = 8'(k + 1);
        end
        @(negedge clk);
        chk("R8 quotient held", 32'(quotient), 32'(hq));
        chk("R8 remainder held", 32'(remainder), 32'(hr));
        chk("R8 quotient value", 32'(hq), 32'hFB);

        // R4/R5 random sign combinations against integer reference
        for (int n = 0; n < NRAND; n++) begin
            logic [N-1:0] ra;
            logic [N-1:0] rb;
            int sa;
            int sb;
            int eq;
            int er;
            ra = 8'($urandom_range(0, 255));
            rb = 8'($urandom_range(0, 255));
            if (rb == 8'h00) rb = 8'h01;
            if (ra == 8'h80 && rb == 8'hFF) rb = 8'hFE;
            sa = int'($signed(ra));
            sb = int'($signed(rb));
            eq = sa / sb;
            er = sa % sb;
            run_div(ra, rb, cyc);
            chk("R4 random quotient", 32'(quotient), 32'(eq[7:0]));
            chk("R5 random remainder", 32'(remainder), 32'(er[7:0]));
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule